// File: doc/BRIEF.md
# Keyed Sequence Watchdog Timer

This block is a hardware watchdog for a small 8-bit controller. It listens on a plain register write bus made of an address, a data byte and a write strobe. It also takes a strobe that marks each machine cycle. After reset it does nothing. Software arms it by writing two key bytes, in a fixed order, to one write-only register. Once armed, it counts machine cycles in a 14-bit counter.

Software must repeat the same two-byte key before the counter runs out. Each time it does, the counter goes back to zero. Software has no way to stop the watchdog once it is armed. Only a hardware reset or the watchdog's own expiry disarms it.

When the count reaches its maximum, the block drives an active-high reset request for a fixed number of raw clocks. At the same moment it disarms itself. The counter value is never visible on the bus.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset `rst_out` is low and the watchdog is dormant. With no writes, `rst_out` stays low for any number of machine cycles.
- R2: The block arms when 0x1E and then 0xE1 are written to address 0xA6 as two consecutive writes to that address. Writes to other addresses in between do not break the sequence.
- R3: A write of 0xE1 to 0xA6 is ignored unless the previous write to 0xA6 was 0x1E. Any other value written to 0xA6 cancels a pending 0x1E, and a repeated 0x1E keeps it pending.
- R4: While armed, the counter advances only on clocks where `mc_en` is high. It overflows in the cycle it holds 16383. `rst_out` rises on the clock edge after that cycle. With `mc_en` held high from the arming write on, `rst_out` is first high 16384 clocks after the edge that took the 0xE1.
- R5: Writing the key pair again while armed clears the counter to zero. A service whose 0xE1 lands while the count is 16382 prevents the overflow.
- R6: While armed, no write of any value to any address disarms the block.
- R7: The reset pulse is active high and lasts exactly 98 clocks. It is timed in raw clocks, independent of `mc_en`.
- R8: An overflow disarms the block and clears the counter. No further pulse occurs until the key pair is written again.
- R9: Asserting `rst_n` disarms the block and ends any pulse at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| mc_en | input | 1 | High for one clock per machine cycle |
| sfr_we | input | 1 | Write strobe of the register bus |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| rst_out | output | 1 | Active-high reset request pulse |

## Verification
The bound checker looks at every cycle. It checks that the counter holds when `mc_en` is low and steps by one when it is high. It checks that an accepted key clears the count, and that the armed state drops only on overflow. It also checks that every pulse follows an overflow and is exactly 98 clocks long.

Some behaviours only show up as long-range outcomes at the ports, so only the bench scenarios can show them. These are the exact clock of the first pulse after arming or servicing, and the rejection of wrong-order or interrupted key pairs. They also include a service landing one count before overflow, and the silence after an overflow or a hardware reset.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

   typedef enum logic {
      KEY_IDLE = 1'b0,
      KEY_PEND = 1'b1
   } key_state_e;

   function automatic int unsigned tmr_width(input int unsigned len);
      return (len < 2) ? 1 : $clog2(len + 1);
   endfunction

endpackage

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
   import kwd_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 8'hA6,
   parameter logic [DATA_W-1:0] KEY_A    = 8'h1E,
   parameter logic [DATA_W-1:0] KEY_B    = 8'hE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              key_hit
);

   key_state_e state_q, state_d;
   logic       reg_sel;
   logic       is_a;
   logic       is_b;

   assign reg_sel = wr_en && (wr_addr == REG_ADDR);
   assign is_a    = (wr_data == KEY_A);
   assign is_b    = (wr_data == KEY_B);

   always_comb begin
      state_d = state_q;
      if (reg_sel) begin
         state_d = is_a ? KEY_PEND : KEY_IDLE;
      end
   end

   assign key_hit = reg_sel && is_b && (state_q == KEY_PEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= KEY_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

endmodule

// File: rtl/kwd_cycle_ctr.sv
module kwd_cycle_ctr #(
   parameter int unsigned CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mc_en,
   input  logic             key_hit,
   output logic             armed,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;

   assign ovf   = armed_q && (cnt_q == CNT_MAX);
   assign armed = armed_q;
   assign count = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (ovf) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (key_hit) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (armed_q && mc_en) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse
   import kwd_pkg::*;
#(
   parameter int unsigned PULSE_LEN = 98
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);

   localparam int unsigned PW = tmr_width(PULSE_LEN);

   generate
      if (PULSE_LEN == 1) begin : g_single
         logic hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hit_q <= 1'b0;
            end else begin
               hit_q <= fire;
            end
         end
         assign pulse = hit_q;
      end else begin : g_timer
         logic [PW-1:0] rem_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rem_q <= '0;
            end else if (fire) begin
               rem_q <= PW'(PULSE_LEN);
            end else if (rem_q != '0) begin
               rem_q <= rem_q - 1'b1;
            end
         end
         assign pulse = (rem_q != '0);
      end
   endgenerate

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 8'hA6,
   parameter logic [DATA_W-1:0] KEY_A    = 8'h1E,
   parameter logic [DATA_W-1:0] KEY_B    = 8'hE1,
   parameter int unsigned CNT_W     = 14,
   parameter int unsigned PULSE_LEN = 98
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mc_en,
   input  logic              sfr_we,
   input  logic [ADDR_W-1:0] sfr_addr,
   input  logic [DATA_W-1:0] sfr_wdata,
   output logic              rst_out
);

   generate
      if (CNT_W < 2 || CNT_W > 30) begin : g_bad_cnt
         $error("keyed_watchdog: CNT_W out of range");
      end
      if (PULSE_LEN < 1) begin : g_bad_len
         $error("keyed_watchdog: PULSE_LEN must be at least 1");
      end
      if (KEY_A == KEY_B) begin : g_bad_key
         $error("keyed_watchdog: the two keys must differ");
      end
   endgenerate

   logic             key_hit;
   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf;

   kwd_key_seq #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .REG_ADDR(REG_ADDR),
      .KEY_A   (KEY_A),
      .KEY_B   (KEY_B)
   ) u_keys (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (sfr_we),
      .wr_addr(sfr_addr),
      .wr_data(sfr_wdata),
      .key_hit(key_hit)
   );

   kwd_cycle_ctr #(
      .CNT_W(CNT_W)
   ) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .mc_en  (mc_en),
      .key_hit(key_hit),
      .armed  (armed_q),
      .count  (cnt_q),
      .ovf    (ovf)
   );

   kwd_pulse #(
      .PULSE_LEN(PULSE_LEN)
   ) u_pulse (
      .clk  (clk),
      .rst_n(rst_n),
      .fire (ovf),
      .pulse(rst_out)
   );

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
   parameter int unsigned CNT_W     = 14,
   parameter int unsigned PULSE_LEN = 98
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mc_en,
   input logic             rst_out,
   input logic             armed,
   input logic             key_hit,
   input logic             ovf,
   input logic [CNT_W-1:0] cnt
);

   int unsigned hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len <= 0;
      end else if (rst_out) begin
         hi_len <= hi_len + 1;
      end else begin
         hi_len <= 0;
      end
   end

   // R4: counter holds between machine cycles
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !mc_en && !key_hit && !ovf) |=> $stable(cnt));

   // R4: counter steps by one on a machine cycle
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && mc_en && !key_hit && !ovf) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   // R5: an accepted key clears the count and leaves the block armed
   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (key_hit && !ovf) |=> (cnt == '0 && armed));

   // R6: nothing but an overflow drops the armed state
   p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !ovf) |=> armed);

   // R7: every pulse starts right after an overflow
   p_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out) |-> $past(ovf));

   // R7: pulse width is exact
   p_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_out) |-> (hi_len == PULSE_LEN));

   // R7: pulse never runs long
   p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_out |-> (hi_len < PULSE_LEN));

   // R8: overflow disarms
   p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (!armed && cnt == '0));

endmodule

bind keyed_watchdog kwd_checker #(
   .CNT_W    (CNT_W),
   .PULSE_LEN(PULSE_LEN)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .mc_en  (mc_en),
   .rst_out(rst_out),
   .armed  (armed_q),
   .key_hit(key_hit),
   .ovf    (ovf),
   .cnt    (cnt_q)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_MAX    = 16383;
   localparam int PULSE      = 98;
   localparam int QUIET      = 17000;
   localparam int WD_LIMIT   = 195000;

   typedef struct {
      int    rise;
      int    width;
      string tag;
   } pulse_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mc_en = 1'b0;
   logic       sfr_we = 1'b0;
   logic [7:0] sfr_addr = '0;
   logic [7:0] sfr_wdata = '0;
   logic       rst_out;

   int     cyc = 0;
   int     tests = 0;
   int     failed = 0;
   int     pulses = 0;
   bit     done = 1'b0;
   pulse_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   keyed_watchdog u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .mc_en    (mc_en),
      .sfr_we   (sfr_we),
      .sfr_addr (sfr_addr),
      .sfr_wdata(sfr_wdata),
      .rst_out  (rst_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      tests++;
      if (!ok) begin
         failed++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d, output int wc);
      sfr_addr  = a;
      sfr_wdata = d;
      sfr_we    = 1'b1;
      wc        = cyc;
      @(negedge clk);
      sfr_we    = 1'b0;
   endtask

   task automatic wr_n(input logic [7:0] a, input logic [7:0] d);
      int wc;
      wr(a, d, wc);
   endtask

   task automatic arm(input int extra, input string tag, output int wc);
      wr_n(8'hA6, 8'h1E);
      wr(8'hA6, 8'hE1, wc);
      exp_q.push_back('{wc + CNT_MAX + 2 + extra, PULSE, tag});
   endtask

   task automatic quiet(input int n, input string req);
      int p0;
      p0 = pulses;
      repeat (n) @(negedge clk);
      chk(pulses == p0 && !rst_out, req, pulses - p0, 0);
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (5) @(negedge clk);
   endtask

   // monitor: pops expected pulses and compares
   bit in_pulse = 1'b0;
   int rise_at  = 0;
   int width    = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         in_pulse = 1'b0;
      end else if (rst_out && !in_pulse) begin
         in_pulse = 1'b1;
         rise_at  = cyc;
         width    = 1;
         pulses++;
      end else if (rst_out) begin
         width++;
      end else if (in_pulse) begin
         in_pulse = 1'b0;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R1 unexpected pulse", rise_at, -1);
         end else begin
            pulse_t e;
            e = exp_q.pop_front();
            chk(rise_at == e.rise, e.tag, rise_at, e.rise);
            chk(width == e.width, "R7", width, e.width);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, failed);
         $finish;
      end
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      chk(1'b0, "watchdog expired", cyc, WD_LIMIT);
      finish_run();
   end

   initial begin
      int wc;
      int wc_arm;
      repeat (3) @(negedge clk);
      chk(rst_out == 1'b0, "R1", rst_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rst_out == 1'b0, "R1", rst_out, 0);

      // R1: dormant with machine cycles running
      mc_en = 1'b1;
      quiet(QUIET, "R1");

      // R3: broken or out-of-order keys never arm
      wr_n(8'hA6, 8'hE1);
      wr_n(8'hA6, 8'h1E);
      wr_n(8'hA6, 8'h00);
      wr_n(8'hA6, 8'hE1);
      wr_n(8'hA6, 8'h1E);
      wr_n(8'h80, 8'hE1);
      wr_n(8'hA6, 8'h55);
      wr_n(8'hA6, 8'hE1);
      quiet(QUIET, "R3");

      // R2: unrelated address between the keys does not break arming
      wr_n(8'hA6, 8'h1E);
      wr_n(8'h80, 8'h77);
      wr(8'hA6, 8'hE1, wc);
      exp_q.push_back('{wc + CNT_MAX + 2, PULSE, "R2"});
      drain();

      // R8: overflow disarmed the block
      quiet(QUIET, "R8");

      // R5: service lands with count at 16382
      arm(0, "R4", wc_arm);
      while (cyc < wc_arm + CNT_MAX - 1) @(negedge clk);
      wr_n(8'hA6, 8'h1E);
      wr(8'hA6, 8'hE1, wc);
      chk(wc == wc_arm + CNT_MAX, "R5 service slot", wc, wc_arm + CNT_MAX);
      void'(exp_q.pop_back());
      exp_q.push_back('{wc + CNT_MAX + 2, PULSE, "R5"});
      drain();

      // R4, R6: machine-cycle gating and junk writes while armed
      mc_en = 1'b0;
      arm(3000, "R4,R6", wc);
      wr_n(8'hA6, 8'h00);
      wr_n(8'hA6, 8'hE1);
      wr_n(8'h10, 8'hFF);
      wr_n(8'hA6, 8'hAA);
      while (cyc < wc + 1 + 3000) @(negedge clk);
      mc_en = 1'b1;
      drain();

      // R9: hardware reset disarms; R3: repeated first key still arms
      wr_n(8'hA6, 8'h1E);
      wr_n(8'hA6, 8'h1E);
      wr(8'hA6, 8'hE1, wc);
      exp_q.push_back('{wc + CNT_MAX + 2, PULSE, "R3"});
      repeat (500) @(negedge clk);
      rst_n = 1'b0;
      void'(exp_q.pop_back());
      repeat (3) @(negedge clk);
      chk(rst_out == 1'b0, "R9", rst_out, 0);
      rst_n = 1'b1;
      quiet(QUIET, "R9");

      chk(exp_q.size() == 0, "R7 pending pulses", exp_q.size(), 0);
      finish_run();
   end

endmodule